// File: doc/BRIEF.md
# Prefixed Shift Execution Unit

This unit carries out the one-bit shift instructions of an 8-bit processor's second (prefixed) opcode page. The rest of the core hands it an opcode with a one-cycle `start` pulse. The unit decodes which shift to perform and which operand to use. The operand is one of seven working registers or the memory byte addressed by the H:L pair. The unit computes the shifted value, writes it back to the same place and updates a 4-bit flag register. After the instruction's fixed cycle count it raises `done`.

Three shifts are supported:
- a left shift that drops the top bit into carry;
- a right shift that keeps the sign bit and drops bit 0 into carry;
- a right shift that fills the top bit with zero and drops bit 0 into carry.

The working registers and the flags are held inside the unit. A simple load port lets the surrounding core set register values. All register contents and the flags are visible on `regOut` and `flags`. The memory operand uses an external synchronous byte memory: the read data returns one cycle after the read strobe.

Top module: `pshift_unit`

## Requirements
- R1: An opcode is accepted only in the ranges 0x20–0x27 (left shift), 0x28–0x2F (sign-keeping right shift) and 0x38–0x3F (zero-fill right shift). Opcode bits [4:3] select the shift kind: 00 left, 01 sign-keeping, 11 zero-fill.
- R2: Opcode bits [2:0] select the operand: 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 6=memory byte at address {H,L}, 7=A. On `regOut`, byte i (bits 8i+7:8i) shows the register with code i, and byte 6 always reads zero.
- R3: The left shift produces the operand shifted left by one and truncated to 8 bits. Carry becomes the operand's old bit 7.
- R4: The sign-keeping right shift moves every bit down by one while bit 7 keeps its value. Carry becomes the old bit 0.
- R5: The zero-fill right shift moves every bit down by one with 0 entering bit 7. Carry becomes the old bit 0.
- R6: `flags` is {Z,N,H,C} on bits 3..0. After every shift, Z is 1 exactly when the 8-bit result is zero, N and H are 0, and C follows R3–R5.
- R7: For a register operand, `done` is high for one cycle starting 7 rising edges after the edge that sampled `start`. The new register value and flags are visible in that same cycle. Only the selected register changes, and no memory strobe is issued.
- R8: For the memory operand, `memRdEn` is high in the cycle right after the start edge, with `memAddr`={H,L}. `memWrEn` is high 14 edges after the start edge, at the same address, carrying the shifted byte. `done` follows 15 edges after the start edge, and no register changes.
- R9: An opcode outside R1's ranges gives a one-cycle `unsupported` pulse in the cycle after the start edge. It raises no `done` and no memory strobe, and it changes no register and no flag.
- R10: While an instruction is in progress (`busy` high), both `start` and the load port are ignored.
- R11: After reset all registers and flags are zero and `busy`, `done`, `unsupported`, `memRdEn` and `memWrEn` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin the instruction given on `opcode` |
| opcode | input | 8 | Prefixed-page opcode |
| ldEn | input | 1 | Write `ldData` into the register selected by `ldSel` |
| ldSel | input | 3 | Register code for the load port (code 6 ignored) |
| ldData | input | 8 | Load value |
| memRdData | input | 8 | Read data from memory, valid one cycle after `memRdEn` |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| unsupported | output | 1 | One-cycle pulse for an opcode that is not handled |
| memRdEn | output | 1 | Memory read strobe |
| memWrEn | output | 1 | Memory write strobe |
| memAddr | output | 16 | Memory address, {H,L} |
| memWrData | output | 8 | Memory write data |
| regOut | output | 64 | All register contents, byte i = register code i |
| flags | output | 4 | {Z,N,H,C} |

## Verification
Each shift kind is tried on operands that tell the kinds apart:
- 0x80 gives zero for the left shift but 0xC0 for the sign-keeping shift.
- 0x01 gives zero with carry for the zero-fill shift.
- 0x81, 0xFF and 0x7E separate the sign bit from the carry source.
- 0x00 and 0x55 test the zero flag and the bit positions.

Every register code is used at least once, so a wrong operand or a wrong write-back target shows up in a neighbouring byte of `regOut`. Memory-form runs check the read and write timing and the address. Unsupported opcodes at 0x30, 0x37, 0x1F, 0x40 and 0xFF must leave everything untouched. A start and a load issued mid-instruction must have no effect.

// File: rtl/pshift_pkg.sv
package pshift_pkg;

  localparam int OPC_W    = 8;
  localparam int SEL_W    = 3;
  localparam logic [SEL_W-1:0] MEM_CODE = 3'd6;

  typedef enum logic [1:0] {
    SHK_LEFT = 2'b00,
    SHK_ASR  = 2'b01,
    SHK_LSR  = 2'b11
  } shKindE;

  // strobes from control to datapath
  typedef struct packed {
    logic idle;    // load port may write
    logic load;    // capture opcode fields
    logic capMem;  // capture memory read data
    logic commit;  // write result and flags
  } ctlStrobeS;

  function automatic logic opIsShift(input logic [OPC_W-1:0] op);
    return (op[7:5] == 3'b001) && (op[4:3] != 2'b10);
  endfunction

  function automatic shKindE opKind(input logic [OPC_W-1:0] op);
    return shKindE'(op[4:3]);
  endfunction

endpackage

// File: rtl/pshift_ctrl.sv
module pshift_ctrl
  import pshift_pkg::*;
#(
  parameter int REG_CYCLES = 8,
  parameter int MEM_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [OPC_W-1:0] opcode,
  output ctlStrobeS        strb,
  output logic             busy,
  output logic             done,
  output logic             unsupported,
  output logic             memRdEn,
  output logic             memWrEn
);

  localparam int CNT_W = $clog2(MEM_CYCLES);
  localparam logic [CNT_W-1:0] REG_LAST = CNT_W'(REG_CYCLES - 2);
  localparam logic [CNT_W-1:0] MEM_LAST = CNT_W'(MEM_CYCLES - 2);

  typedef enum logic {ST_IDLE, ST_RUN} stateE;

  stateE            stateQ;
  logic [CNT_W-1:0] cntQ;
  logic             isMemQ;
  logic             lastCycle;
  logic             accept;

  assign accept    = (stateQ == ST_IDLE) && start && opIsShift(opcode);
  assign lastCycle = (stateQ == ST_RUN) && (cntQ == (isMemQ ? MEM_LAST : REG_LAST));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ      <= ST_IDLE;
      cntQ        <= '0;
      isMemQ      <= 1'b0;
      done        <= 1'b0;
      unsupported <= 1'b0;
    end else begin
      done        <= 1'b0;
      unsupported <= 1'b0;
      case (stateQ)
        ST_IDLE: begin
          if (accept) begin
            stateQ <= ST_RUN;
            cntQ   <= '0;
            isMemQ <= (opcode[SEL_W-1:0] == MEM_CODE);
          end else if (start) begin
            unsupported <= 1'b1;
          end
        end
        default: begin
          if (lastCycle) begin
            stateQ <= ST_IDLE;
            done   <= 1'b1;
          end else begin
            cntQ <= cntQ + 1'b1;
          end
        end
      endcase
    end
  end

  assign busy    = (stateQ == ST_RUN);
  assign memRdEn = busy && isMemQ && (cntQ == '0);
  assign memWrEn = lastCycle && isMemQ;

  always_comb begin
    strb.idle   = !busy;
    strb.load   = accept;
    strb.capMem = busy && isMemQ && (cntQ == CNT_W'(1));
    strb.commit = lastCycle;
  end

endmodule

// File: rtl/pshift_dp.sv
module pshift_dp
  import pshift_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctlStrobeS                 strb,
  input  logic [OPC_W-1:0]          opcode,
  input  logic                      ldEn,
  input  logic [SEL_W-1:0]          ldSel,
  input  logic [DATA_W-1:0]         ldData,
  input  logic [DATA_W-1:0]         memRdData,
  output logic [2*DATA_W-1:0]       memAddr,
  output logic [DATA_W-1:0]         memWrData,
  output logic [(1<<SEL_W)*DATA_W-1:0] regOut,
  output logic [3:0]                flags
);

  localparam int NUM_SLOTS = 1 << SEL_W;
  localparam logic [SEL_W-1:0] IDX_H = 3'd4;
  localparam logic [SEL_W-1:0] IDX_L = 3'd5;

  logic [DATA_W-1:0] regQ [NUM_SLOTS];
  logic [DATA_W-1:0] memByteQ;
  logic [SEL_W-1:0]  selQ;
  shKindE            kindQ;
  logic [3:0]        flagQ;

  logic [DATA_W-1:0] operand;
  logic [DATA_W-1:0] shRes;
  logic              shCarry;

  assign operand = (selQ == MEM_CODE) ? memByteQ : regQ[selQ];

  always_comb begin
    case (kindQ)
      SHK_LEFT: begin
        shRes   = {operand[DATA_W-2:0], 1'b0};
        shCarry = operand[DATA_W-1];
      end
      SHK_ASR: begin
        shRes   = {operand[DATA_W-1], operand[DATA_W-1:1]};
        shCarry = operand[0];
      end
      default: begin
        shRes   = {1'b0, operand[DATA_W-1:1]};
        shCarry = operand[0];
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SLOTS; i++) regQ[i] <= '0;
      memByteQ <= '0;
      selQ     <= '0;
      kindQ    <= SHK_LEFT;
      flagQ    <= '0;
    end else begin
      if (strb.load) begin
        selQ  <= opcode[SEL_W-1:0];
        kindQ <= opKind(opcode);
      end
      if (strb.capMem) memByteQ <= memRdData;
      if (strb.commit) begin
        flagQ <= {(shRes == '0), 1'b0, 1'b0, shCarry};
        if (selQ != MEM_CODE) regQ[selQ] <= shRes;
      end else if (strb.idle && ldEn && (ldSel != MEM_CODE)) begin
        regQ[ldSel] <= ldData;
      end
    end
  end

  assign memAddr   = {regQ[IDX_H], regQ[IDX_L]};
  assign memWrData = shRes;
  assign flags     = flagQ;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_view
    if (g == int'(MEM_CODE)) begin : g_hole
      assign regOut[g*DATA_W +: DATA_W] = '0;
    end else begin : g_reg
      assign regOut[g*DATA_W +: DATA_W] = regQ[g];
    end
  end

endmodule

// File: rtl/pshift_unit.sv
module pshift_unit
  import pshift_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int REG_CYCLES = 8,
  parameter int MEM_CYCLES = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [7:0]            opcode,
  input  logic                  ldEn,
  input  logic [2:0]            ldSel,
  input  logic [DATA_W-1:0]     ldData,
  input  logic [DATA_W-1:0]     memRdData,
  output logic                  busy,
  output logic                  done,
  output logic                  unsupported,
  output logic                  memRdEn,
  output logic                  memWrEn,
  output logic [2*DATA_W-1:0]   memAddr,
  output logic [DATA_W-1:0]     memWrData,
  output logic [8*DATA_W-1:0]   regOut,
  output logic [3:0]            flags
);

  ctlStrobeS strb;

  pshift_ctrl #(
    .REG_CYCLES(REG_CYCLES),
    .MEM_CYCLES(MEM_CYCLES)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .opcode     (opcode),
    .strb       (strb),
    .busy       (busy),
    .done       (done),
    .unsupported(unsupported),
    .memRdEn    (memRdEn),
    .memWrEn    (memWrEn)
  );

  pshift_dp #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .opcode    (opcode),
    .ldEn      (ldEn),
    .ldSel     (ldSel),
    .ldData    (ldData),
    .memRdData (memRdData),
    .memAddr   (memAddr),
    .memWrData (memWrData),
    .regOut    (regOut),
    .flags     (flags)
  );

endmodule

// File: rtl/pshift_chk.sv
module pshift_chk #(
  parameter int DATA_W     = 8,
  parameter int REG_CYCLES = 8,
  parameter int MEM_CYCLES = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                busy,
  input logic                done,
  input logic                unsupported,
  input logic                memRdEn,
  input logic                memWrEn,
  input logic [2*DATA_W-1:0] memAddr,
  input logic [DATA_W-1:0]   memWrData,
  input logic [3:0]          flags
);

  localparam int LEN_W = $clog2(MEM_CYCLES) + 1;

  logic [LEN_W-1:0] busyLen;
  logic             sawRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyLen <= '0;
      sawRead <= 1'b0;
    end else begin
      busyLen <= busy ? busyLen + 1'b1 : '0;
      if (memRdEn) sawRead <= 1'b1;
      else if (done) sawRead <= 1'b0;
    end
  end

  // R7 and R8: instruction length from start edge to done
  a_r7_done_timing: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busyLen == (sawRead ? LEN_W'(MEM_CYCLES - 1) : LEN_W'(REG_CYCLES - 1)));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r8_read_wait: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> (!memWrEn && !memRdEn && busy));

  a_r8_write_then_done: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> done);

  a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(memAddr));

  a_r6_zero_flag: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> (flags[3] == ($past(memWrData) == '0)));

  a_r6_nh_clear: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (flags[2:1] == 2'b00));

  a_r9_unsup_quiet: assert property (@(posedge clk) disable iff (!rstN)
    unsupported |-> (!busy && !memRdEn && !memWrEn));

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({done, unsupported, memRdEn, memWrEn}));

endmodule

bind pshift_unit pshift_chk #(
  .DATA_W    (DATA_W),
  .REG_CYCLES(REG_CYCLES),
  .MEM_CYCLES(MEM_CYCLES)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busy       (busy),
  .done       (done),
  .unsupported(unsupported),
  .memRdEn    (memRdEn),
  .memWrEn    (memWrEn),
  .memAddr    (memAddr),
  .memWrData  (memWrData),
  .flags      (flags)
);

// File: tb/sim_pshift_unit.sv
`timescale 1ns/1ps
module sim_pshift_unit;

  localparam int REG_N = 8;
  localparam int MEM_N = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0;
  logic        ldEn = 1'b0;
  logic [2:0]  ldSel = '0;
  logic [7:0]  ldData = '0;
  logic [7:0]  memRdData;
  logic        busy, done, unsupported, memRdEn, memWrEn;
  logic [15:0] memAddr;
  logic [7:0]  memWrData;
  logic [63:0] regOut;
  logic [3:0]  flags;

  int checks = 0;
  int failures = 0;

  logic [7:0] model [8];
  logic [3:0] modelFlags;

  // bench memory (256 bytes, low address byte)
  logic [7:0] memArr [256];
  logic       pokeEn = 1'b0;
  logic [7:0] pokeAddr = '0;
  logic [7:0] pokeData = '0;

  always #2 clk = ~clk;

  pshift_unit u0 (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
    .ldEn(ldEn), .ldSel(ldSel), .ldData(ldData), .memRdData(memRdData),
    .busy(busy), .done(done), .unsupported(unsupported),
    .memRdEn(memRdEn), .memWrEn(memWrEn), .memAddr(memAddr),
    .memWrData(memWrData), .regOut(regOut), .flags(flags)
  );

  always @(posedge clk) begin
    if (pokeEn) memArr[pokeAddr] <= pokeData;
    if (memRdEn) memRdData <= memArr[memAddr[7:0]];
    if (memWrEn) memArr[memAddr[7:0]] <= memWrData;
  end

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] packModel();
    logic [63:0] v = '0;
    for (int i = 0; i < 8; i++) if (i != 6) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  // expected shift per requirements R3, R4, R5
  function automatic logic [8:0] expShift(input logic [1:0] kind, input logic [7:0] v);
    logic [7:0] r;
    logic c;
    if (kind == 2'b00) begin r = v << 1; c = v[7]; end
    else if (kind == 2'b01) begin r = (v >> 1) | (v & 8'h80); c = v[0]; end
    else begin r = v >> 1; c = v[0]; end
    return {c, r};
  endfunction

  task automatic loadReg(input logic [2:0] sel, input logic [7:0] val);
    @(negedge clk);
    ldEn = 1'b1; ldSel = sel; ldData = val;
    @(negedge clk);
    ldEn = 1'b0;
    if (sel != 3'd6) model[sel] = val;
  endtask

  task automatic pokeMem(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    pokeEn = 1'b1; pokeAddr = a; pokeData = d;
    @(negedge clk);
    pokeEn = 1'b0;
  endtask

  task automatic runOp(input logic [7:0] op, input string tag);
    int doneAt = -1;
    int rdAt = -1;
    int wrAt = -1;
    logic [15:0] rdAddr = '0;
    logic [15:0] wrAddr = '0;
    logic [7:0]  wrData = '0;
    logic [63:0] regAtDone = '0;
    logic [3:0]  flagsAtDone = '0;
    logic        isMem = (op[2:0] == 3'd6);
    logic [15:0] hl = {model[4], model[5]};
    logic [7:0]  v;
    logic [8:0]  e;
    int          n;
    v = isMem ? memArr[hl[7:0]] : model[op[2:0]];
    e = expShift(op[4:3], v);
    n = isMem ? MEM_N : REG_N;
    @(negedge clk);
    start = 1'b1; opcode = op;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 40; k++) begin
      if (memRdEn && rdAt < 0) begin rdAt = k; rdAddr = memAddr; end
      if (memWrEn && wrAt < 0) begin wrAt = k; wrAddr = memAddr; wrData = memWrData; end
      if (done && doneAt < 0) begin doneAt = k; regAtDone = regOut; flagsAtDone = flags; end
      @(negedge clk);
    end
    if (!isMem) model[op[2:0]] = e[7:0];
    modelFlags = {(e[7:0] == 8'h00), 2'b00, e[8]};
    chk(doneAt == n - 1, isMem ? {tag, " R8 done timing"} : {tag, " R7 done timing"}, 64'(doneAt), 64'(n - 1));
    chk(regAtDone == packModel(), {tag, " R2 R7 register file"}, regAtDone, packModel());
    chk(flagsAtDone == modelFlags, {tag, " R6 flags"}, 64'(flagsAtDone), 64'(modelFlags));
    if (isMem) begin
      chk(rdAt == 0 && rdAddr == hl, {tag, " R8 read strobe"}, {32'(rdAt), 16'h0, rdAddr}, {32'h0, 16'h0, hl});
      chk(wrAt == n - 2 && wrAddr == hl, {tag, " R8 write strobe"}, {32'(wrAt), 16'h0, wrAddr}, {32'(n - 2), 16'h0, hl});
      chk(wrData == e[7:0], {tag, " R8 write data"}, 64'(wrData), 64'(e[7:0]));
    end else begin
      chk(rdAt < 0 && wrAt < 0, {tag, " R7 no memory access"}, {32'(rdAt), 32'(wrAt)}, {32'hffffffff, 32'hffffffff});
    end
  endtask

  task automatic runUnsupported(input logic [7:0] op);
    logic [63:0] regBefore = regOut;
    logic [3:0]  flagsBefore = flags;
    logic        pulse;
    int          extra = 0;
    @(negedge clk);
    start = 1'b1; opcode = op;
    @(negedge clk);
    start = 1'b0;
    pulse = unsupported;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (done || memRdEn || memWrEn || unsupported || busy) extra++;
    end
    chk(pulse == 1'b1, $sformatf("R9 unsupported pulse op=%0h", op), 64'(pulse), 64'd1);
    chk(extra == 0, $sformatf("R1 R9 no activity op=%0h", op), 64'(extra), 64'd0);
    chk(regOut == regBefore && flags == flagsBefore, $sformatf("R9 state kept op=%0h", op),
        {regOut[59:0], flags}, {regBefore[59:0], flagsBefore});
  endtask

  task automatic testReset();
    chk(regOut == 64'h0 && flags == 4'h0, "R11 reset state", {regOut[59:0], flags}, 64'h0);
    chk({busy, done, unsupported, memRdEn, memWrEn} == 5'b0, "R11 reset outputs",
        64'({busy, done, unsupported, memRdEn, memWrEn}), 64'h0);
  endtask

  task automatic testLoad();
    loadReg(3'd0, 8'h80); loadReg(3'd1, 8'h81); loadReg(3'd2, 8'h01);
    loadReg(3'd3, 8'h80); loadReg(3'd4, 8'hFF); loadReg(3'd5, 8'h00);
    loadReg(3'd7, 8'h7E); loadReg(3'd6, 8'hAA);
    @(negedge clk);
    chk(regOut == packModel(), "R2 load and view layout", regOut, packModel());
  endtask

  task automatic testRegisterForms();
    runOp(8'h20, "SL B 0x80 R1 R3");
    runOp(8'h29, "SA C 0x81 R4");
    runOp(8'h3A, "SZ D 0x01 R5");
    runOp(8'h2B, "SA E 0x80 R4");
    runOp(8'h3C, "SZ H 0xFF R5");
    runOp(8'h25, "SL L 0x00 R3");
    runOp(8'h2F, "SA A 0x7E R4");
    loadReg(3'd7, 8'h55);
    runOp(8'h27, "SL A 0x55 R3");
  endtask

  task automatic testMemoryForms();
    loadReg(3'd4, 8'h12); loadReg(3'd5, 8'h34);
    pokeMem(8'h34, 8'h96);
    runOp(8'h2E, "SA mem 0x96 R4");
    runOp(8'h26, "SL mem R3");
    pokeMem(8'h34, 8'h80);
    runOp(8'h26, "SL mem 0x80 R3");
    pokeMem(8'h34, 8'h01);
    runOp(8'h3E, "SZ mem 0x01 R5");
  endtask

  task automatic testUnsupported();
    runUnsupported(8'h30);
    runUnsupported(8'h37);
    runUnsupported(8'h1F);
    runUnsupported(8'h40);
    runUnsupported(8'hFF);
  endtask

  task automatic testBusyIgnore();
    logic [8:0]  e;
    int          doneCount = 0;
    int          doneAt = -1;
    loadReg(3'd0, 8'hC3);
    e = expShift(2'b00, 8'hC3);
    @(negedge clk);
    start = 1'b1; opcode = 8'h20;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 30; k++) begin
      if (k == 3) begin start = 1'b1; opcode = 8'h3F; ldEn = 1'b1; ldSel = 3'd0; ldData = 8'h11; end
      if (k == 4) begin start = 1'b0; ldEn = 1'b0; end
      if (done) begin doneCount++; if (doneAt < 0) doneAt = k; end
      @(negedge clk);
    end
    model[0] = e[7:0];
    chk(doneCount == 1 && doneAt == REG_N - 1, "R10 start ignored while busy",
        {32'(doneCount), 32'(doneAt)}, {32'd1, 32'(REG_N - 1)});
    chk(regOut == packModel(), "R10 load ignored while busy", regOut, packModel());
  endtask

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    for (int i = 0; i < 256; i++) memArr[i] = '0;
    modelFlags = '0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testLoad();
    testRegisterForms();
    testMemoryForms();
    testUnsupported();
    testBusyIgnore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule